// File: doc/BRIEF.md
# Hit-aware multi-port memory command arbiter

The block sits between four requesters and a memory whose banks each keep one row buffer, here called a channel. Every request moves one unbroken quad word, so a larger transfer arrives as several requests. For each channel the block keeps a valid bit and the row address last loaded into it. It classifies each pending request as a hit or a miss and issues one memory command per clock cycle. A hit needs a single read or write command. A miss needs an activate, then a load of the row into the channel (called a fill here), then the read or write command.

Priority is fixed, with port 0 first and port 3 last. The fill must follow its activate by a programmable distance. While the arbiter waits out that gap, it may serve hits from other ports. A slow miss then does not hold up cheap hits, and the next new sequence still goes to the highest-priority pending port. Each port carries a channel mask. A port can hit in, or load, only the channels its mask allows, so channels can be reserved for particular requesters.

The controller has three states. In `S_IDLE` it picks the highest-priority pending port. If that port hits, it issues the access and stays in `S_IDLE`. If it misses, it issues the activate and moves to `S_WAIT`. In `S_WAIT` a counter runs down the gap and each free slot may carry a hit access. When the counter reaches zero the arbiter issues the fill and moves to `S_ACCESS`. `S_ACCESS` issues the access for the missing port and returns to `S_IDLE`.

Top module: `chan_cmd_arbiter`

## Requirements
- R1: During and after reset, `cmd_op_o` is NOP (0) and `done_o` is zero. All channel tags are invalid, so the first request to any channel is served as a miss.
- R2: When several ports are pending, each new sequence starts with the lowest-numbered pending port. Four simultaneous hits are served in port order 0, 1, 2, 3 on consecutive cycles.
- R3: A miss on port p is served as ACT (1), then FILL (2), then the access. All three carry the port's channel and row, and `cmd_port_o` = p. The access follows the fill in the very next cycle.
- R4: A hit is served by a single access command: RD (3) when `wr_i[p]`=0, WR (4) when `wr_i[p]`=1. The command appears in the cycle after the request is first sampled.
- R5: The fill comes exactly max(`gap_i`,1) cycles after its activate.
- R6: In the cycles strictly between an activate and its fill, the arbiter serves the highest-priority pending hit from another port, one per cycle. This holds even when the hitting port has lower priority than the missing port.
- R7: `done_o` is at most one-hot. It pulses for exactly the cycle in which that port's access command is on the output, with `cmd_port_o` naming the port. A request still high during its done cycle is ignored, and the requester drops it in that cycle.
- R8: After a fill, the channel holds the filled row. A later request to the same channel and row hits; a different row in that channel misses.
- R9: Bit c of port p's mask sits at `chmask_i[p*4+c]`. If that bit is clear, the port's requests to channel c always miss, and its fills leave channel c's tag unchanged.
- R10: Only one miss sequence runs at a time. A second pending miss gets its activate in the cycle after the first miss's access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 4 | Request per port, held until done |
| wr_i | input | 4 | Per port: 1 write, 0 read |
| chan_i | input | 8 | Target channel per port, 2 bits each |
| row_i | input | 32 | Row address per port, 8 bits each |
| chmask_i | input | 16 | Allowed channels per port, 4 bits each |
| gap_i | input | 4 | Activate-to-fill distance in cycles (0 treated as 1) |
| cmd_op_o | output | 3 | Command: 0 NOP, 1 ACT, 2 FILL, 3 RD, 4 WR |
| cmd_chan_o | output | 2 | Channel of the command |
| cmd_row_o | output | 8 | Row of the command |
| cmd_port_o | output | 2 | Port the command serves |
| done_o | output | 4 | One-cycle completion pulse per port |

## Verification
The arbiter decides at one rising edge and shows the command on the next cycle. A request raised at a falling edge therefore yields its first command at the following falling edge. Every later command lands a fixed number of cycles after that: the fill at max(gap,1) cycles after the activate, and the miss access one cycle after the fill. The bench logs each non-NOP command with the falling-edge cycle count at which it was seen. It compares both content and offset from the first command of the scenario against an order it computes from the gap and the two port numbers. The done pulse is checked in the same sample as the access it belongs to.

// File: rtl/chan_arb_pkg.sv
package chan_arb_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_FILL = 3'd2,
        OP_RD   = 3'd3,
        OP_WR   = 3'd4
    } cmd_op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_ACCESS
    } arb_state_e;

endpackage

// File: rtl/fixed_prio_pick.sv
module fixed_prio_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    // lowest index wins: scan downward so the last hit written is the lowest
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                any_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/chan_tag_table.sv
module chan_tag_table #(
    parameter int NP  = 4,
    parameter int NCH = 4,
    parameter int RW  = 8,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NP*CW-1:0]  chan_i,
    input  logic [NP*RW-1:0]  row_i,
    input  logic [NP*NCH-1:0] mask_i,
    input  logic              upd_en_i,
    input  logic [CW-1:0]     upd_chan_i,
    input  logic [RW-1:0]     upd_row_i,
    output logic [NP-1:0]     hit_o
);

    logic [RW-1:0]  tag_q [NCH];
    logic [NCH-1:0] val_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            for (int c = 0; c < NCH; c++) tag_q[c] <= '0;
        end else if (upd_en_i) begin
            val_q[upd_chan_i] <= 1'b1;
            tag_q[upd_chan_i] <= upd_row_i;
        end
    end

    for (genvar p = 0; p < NP; p++) begin : g_port
        logic [CW-1:0]  pc;
        logic [RW-1:0]  pr;
        logic [NCH-1:0] pm;
        assign pc       = chan_i[p*CW +: CW];
        assign pr       = row_i[p*RW +: RW];
        assign pm       = mask_i[p*NCH +: NCH];
        assign hit_o[p] = pm[pc] & val_q[pc] & (tag_q[pc] == pr);
    end

    AST_TAG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en_i |=> (val_q[$past(upd_chan_i)] && (tag_q[$past(upd_chan_i)] == $past(upd_row_i)))); // R8

endmodule

// File: rtl/chan_cmd_arbiter.sv
module chan_cmd_arbiter
    import chan_arb_pkg::*;
#(
    parameter int NP  = 4,
    parameter int NCH = 4,
    parameter int RW  = 8,
    parameter int GW  = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NP-1:0]     req_i,
    input  logic [NP-1:0]     wr_i,
    input  logic [NP*CW-1:0]  chan_i,
    input  logic [NP*RW-1:0]  row_i,
    input  logic [NP*NCH-1:0] chmask_i,
    input  logic [GW-1:0]     gap_i,
    output logic [2:0]        cmd_op_o,
    output logic [CW-1:0]     cmd_chan_o,
    output logic [RW-1:0]     cmd_row_o,
    output logic [PW-1:0]     cmd_port_o,
    output logic [NP-1:0]     done_o
);

    arb_state_e    state_q, state_d;
    logic [GW-1:0] cnt_q, cnt_d, gap_load;
    logic [PW-1:0] miss_q, miss_d;

    cmd_op_e       op_q, op_d;
    logic [CW-1:0] chan_q, chan_d;
    logic [RW-1:0] row_q, row_d;
    logic [PW-1:0] port_q, port_d;
    logic [NP-1:0] done_q, done_d;

    logic [CW-1:0] chan_a [NP];
    logic [RW-1:0] row_a  [NP];

    for (genvar p = 0; p < NP; p++) begin : g_unpack
        assign chan_a[p] = chan_i[p*CW +: CW];
        assign row_a[p]  = row_i[p*RW +: RW];
    end

    // a port whose done is showing has been served; its request is ignored
    logic [NP-1:0]  req_eff, hit_w, hit_cand, excl;
    logic           any_all, any_hit, acc_go, upd_en;
    logic [PW-1:0]  top_p, hit_p, acc_p;
    logic [NCH-1:0] miss_mask;

    assign req_eff   = req_i & ~done_q;
    assign excl      = (state_q == S_WAIT) ? (NP'(1) << miss_q) : '0;
    assign hit_cand  = req_eff & hit_w & ~excl;
    assign gap_load  = (gap_i == '0) ? '0 : gap_i - GW'(1);
    assign miss_mask = chmask_i[int'(miss_q)*NCH +: NCH];
    assign upd_en    = (state_q == S_WAIT) && (cnt_q == '0) && miss_mask[chan_a[miss_q]];

    chan_tag_table #(.NP(NP), .NCH(NCH), .RW(RW)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_i     (chan_i),
        .row_i      (row_i),
        .mask_i     (chmask_i),
        .upd_en_i   (upd_en),
        .upd_chan_i (chan_a[miss_q]),
        .upd_row_i  (row_a[miss_q]),
        .hit_o      (hit_w)
    );

    fixed_prio_pick #(.N(NP)) u_pick_all (
        .vec_i (req_eff),
        .any_o (any_all),
        .idx_o (top_p)
    );

    fixed_prio_pick #(.N(NP)) u_pick_hit (
        .vec_i (hit_cand),
        .any_o (any_hit),
        .idx_o (hit_p)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            miss_q  <= miss_d;
        end
    end

    // next state and next command
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        miss_d  = miss_q;
        op_d    = OP_NOP;
        chan_d  = '0;
        row_d   = '0;
        port_d  = '0;
        done_d  = '0;
        acc_go  = 1'b0;
        acc_p   = '0;
        unique case (state_q)
            S_IDLE: begin
                if (any_all) begin
                    if (hit_w[top_p]) begin
                        acc_go = 1'b1;
                        acc_p  = top_p;
                    end else begin
                        op_d    = OP_ACT;
                        chan_d  = chan_a[top_p];
                        row_d   = row_a[top_p];
                        port_d  = top_p;
                        miss_d  = top_p;
                        cnt_d   = gap_load;
                        state_d = S_WAIT;
                    end
                end
            end
            S_WAIT: begin
                if (cnt_q == '0) begin
                    op_d    = OP_FILL;
                    chan_d  = chan_a[miss_q];
                    row_d   = row_a[miss_q];
                    port_d  = miss_q;
                    state_d = S_ACCESS;
                end else begin
                    cnt_d = cnt_q - GW'(1);
                    if (any_hit) begin
                        acc_go = 1'b1;
                        acc_p  = hit_p;
                    end
                end
            end
            S_ACCESS: begin
                acc_go  = 1'b1;
                acc_p   = miss_q;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
        if (acc_go) begin
            op_d          = wr_i[acc_p] ? OP_WR : OP_RD;
            chan_d        = chan_a[acc_p];
            row_d         = row_a[acc_p];
            port_d        = acc_p;
            done_d[acc_p] = 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_NOP;
            chan_q <= '0;
            row_q  <= '0;
            port_q <= '0;
            done_q <= '0;
        end else begin
            op_q   <= op_d;
            chan_q <= chan_d;
            row_q  <= row_d;
            port_q <= port_d;
            done_q <= done_d;
        end
    end

    assign cmd_op_o   = op_q;
    assign cmd_chan_o = chan_q;
    assign cmd_row_o  = row_q;
    assign cmd_port_o = port_q;
    assign done_o     = done_q;

    // cycles since the last activate on the output, saturating
    logic [GW:0] since_q, gap_eff;
    assign gap_eff = (gap_i == '0) ? (GW+1)'(1) : {1'b0, gap_i};

    always_ff @(posedge clk) begin
        if (!rst_n)                 since_q <= '0;
        else if (op_q == OP_ACT)    since_q <= (GW+1)'(1);
        else if (since_q != '1)     since_q <= since_q + (GW+1)'(1);
    end

    AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_o)); // R7
    AST_DONE_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o != '0) |-> ((op_q == OP_RD || op_q == OP_WR) && done_o[cmd_port_o])); // R7
    AST_GAP_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_FILL) |-> (since_q >= gap_eff)); // R5
    AST_FILL_THEN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_FILL) |=> (op_q == OP_RD || op_q == OP_WR)); // R3
    AST_NO_BACK_TO_BACK_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_ACT) |=> (op_q != OP_ACT)); // R10

endmodule

// File: tb/chan_cmd_arbiter_test.sv
module chan_cmd_arbiter_test;

    localparam int NP = 4, NCH = 4, RW = 8, GW = 4, CW = 2, PW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     req_r = '0;
    logic [NP-1:0]     wr_r = '0;
    logic [NP*CW-1:0]  chan_r = '0;
    logic [NP*RW-1:0]  row_r = '0;
    logic [NP*NCH-1:0] mask_r = '1;
    logic [GW-1:0]     gap_r = 4'd2;
    logic [2:0]        op;
    logic [CW-1:0]     cch;
    logic [RW-1:0]     crow;
    logic [PW-1:0]     cport;
    logic [NP-1:0]     done;

    chan_cmd_arbiter #(.NP(NP), .NCH(NCH), .RW(RW), .GW(GW)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_r), .wr_i(wr_r), .chan_i(chan_r),
        .row_i(row_r), .chmask_i(mask_r), .gap_i(gap_r), .cmd_op_o(op),
        .cmd_chan_o(cch), .cmd_row_o(crow), .cmd_port_o(cport), .done_o(done)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0, lg_n = 0;
    logic [2:0]    lg_op   [64];
    logic [CW-1:0] lg_ch   [64];
    logic [RW-1:0] lg_row  [64];
    logic [PW-1:0] lg_port [64];
    int            lg_cyc  [64];

    task automatic note(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // monitor and requester: log commands, check done, drop served requests
    initial forever begin
        @(negedge clk);
        cyc++;
        if (rst_n) begin
            if (op != 3'd0) begin
                if (lg_n < 64) begin
                    lg_op[lg_n] = op; lg_ch[lg_n] = cch; lg_row[lg_n] = crow;
                    lg_port[lg_n] = cport; lg_cyc[lg_n] = cyc;
                end
                lg_n++;
            end
            if (op == 3'd3 || op == 3'd4)
                note(done == (4'b1 << cport), "R7", "done with access", int'(done), 1 << cport);
            else if (done != '0)
                note(1'b0, "R7", "done without access", int'(done), 0);
        end
        req_r = req_r & ~done;
    end

    initial begin
        repeat (150000) @(posedge clk);
        note(1'b0, "watchdog", "run did not finish", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic do_reset(input int g);
        @(negedge clk);
        rst_n = 1'b0; req_r = '0; gap_r = GW'(g); mask_r = '1;
        @(negedge clk);
        @(negedge clk);
        note(op == 3'd0 && done == '0, "R1", "reset outputs", int'(op) * 16 + int'(done), 0);
        rst_n = 1'b1;
        lg_n = 0;
    endtask

    task automatic set_port(input int p, input int ch, input int row, input bit wr);
        chan_r[p*CW +: CW] = CW'(ch);
        row_r[p*RW +: RW]  = RW'(row);
        wr_r[p]            = wr;
    endtask

    task automatic raise(input logic [NP-1:0] bits);
        @(negedge clk);
        lg_n = 0;
        req_r = req_r | bits;
    endtask

    task automatic wait_idle();
        while (req_r != '0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic exp_cmd(input int i, input int eop, input int ch, input int row,
                           input int port, input int off, input string rq);
        if (i >= lg_n || i >= 64) begin
            note(1'b0, rq, $sformatf("command %0d missing", i), lg_n, i + 1);
        end else begin
            note(lg_op[i] == 3'(eop) && lg_ch[i] == CW'(ch) && lg_row[i] == RW'(row) && lg_port[i] == PW'(port),
                 rq, $sformatf("command %0d op/chan/row/port", i),
                 int'(lg_op[i]) * 65536 + int'(lg_ch[i]) * 4096 + int'(lg_row[i]) * 16 + int'(lg_port[i]),
                 eop * 65536 + ch * 4096 + row * 16 + port);
            note(lg_cyc[i] - lg_cyc[0] == off, rq, $sformatf("command %0d offset", i),
                 lg_cyc[i] - lg_cyc[0], off);
        end
    endtask

    function automatic int acc_op(input bit wr);
        return wr ? 4 : 3;
    endfunction

    // full miss sequence for one port, starting from an idle arbiter
    task automatic miss_seq(input int p, input int ch, input int row, input bit wr, input int ge, input string rq);
        set_port(p, ch, row, wr);
        raise(NP'(1) << p);
        wait_idle();
        exp_cmd(0, 1, ch, row, p, 0, rq);
        exp_cmd(1, 2, ch, row, p, ge, "R5");
        exp_cmd(2, acc_op(wr), ch, row, p, ge + 1, rq);
        note(lg_n == 3, rq, "command count", lg_n, 3);
    endtask

    initial begin
        // sweep: one miss port and one hit port raised together, every gap 0..4
        for (int g = 0; g <= 4; g++) begin
            for (int m = 0; m < NP; m++) begin
                for (int h = 0; h < NP; h++) begin
                    if (m != h) begin
                        automatic int ge = (g == 0) ? 1 : g;
                        automatic bit wm = 1'((m + g) % 2);
                        automatic bit wh = 1'((h + g + 1) % 2);
                        automatic int rm = 8'h60 + m * 8 + g;
                        automatic int rh = 8'h20 + h;
                        do_reset(g);
                        miss_seq(h, h, rh, 1'b0, ge, "R1 R3");
                        set_port(m, m, rm, wm);
                        set_port(h, h, rh, wh);
                        raise((NP'(1) << m) | (NP'(1) << h));
                        wait_idle();
                        if (m < h) begin
                            exp_cmd(0, 1, m, rm, m, 0, "R2");
                            if (ge >= 2) begin
                                exp_cmd(1, acc_op(wh), h, rh, h, 1, "R6");
                                exp_cmd(2, 2, m, rm, m, ge, "R5");
                                exp_cmd(3, acc_op(wm), m, rm, m, ge + 1, "R3");
                            end else begin
                                exp_cmd(1, 2, m, rm, m, 1, "R5");
                                exp_cmd(2, acc_op(wm), m, rm, m, 2, "R3");
                                exp_cmd(3, acc_op(wh), h, rh, h, 3, "R4");
                            end
                        end else begin
                            exp_cmd(0, acc_op(wh), h, rh, h, 0, "R2");
                            exp_cmd(1, 1, m, rm, m, 1, "R3");
                            exp_cmd(2, 2, m, rm, m, 1 + ge, "R5");
                            exp_cmd(3, acc_op(wm), m, rm, m, 2 + ge, "R3");
                        end
                        note(lg_n == 4, "R6", "command count", lg_n, 4);
                    end
                end
            end
        end

        // four simultaneous hits: port order
        do_reset(2);
        for (int p = 0; p < NP; p++) miss_seq(p, p, 8'h30 + p, 1'b0, 2, "R3");
        raise('1);
        wait_idle();
        for (int p = 0; p < NP; p++) exp_cmd(p, 3, p, 8'h30 + p, p, p, "R2");

        // hit latency, tag reuse and tag replacement
        raise(4'b0010);
        @(negedge clk);
        note(op == 3'd3 && cport == 2'd1, "R4", "hit access one cycle after request", int'(op), 3);
        wait_idle();
        note(lg_n == 1, "R8", "same row served by one access", lg_n, 1);
        miss_seq(1, 1, 8'h3A, 1'b1, 2, "R8");
        raise(4'b0010);
        wait_idle();
        exp_cmd(0, 4, 1, 8'h3A, 1, 0, "R8");

        // two misses at once: serialised, lower port first
        do_reset(3);
        set_port(0, 0, 8'h11, 1'b0);
        set_port(2, 2, 8'h12, 1'b1);
        raise(4'b0101);
        wait_idle();
        exp_cmd(0, 1, 0, 8'h11, 0, 0, "R2");
        exp_cmd(1, 2, 0, 8'h11, 0, 3, "R5");
        exp_cmd(2, 3, 0, 8'h11, 0, 4, "R3");
        exp_cmd(3, 1, 2, 8'h12, 2, 5, "R10");
        exp_cmd(4, 2, 2, 8'h12, 2, 8, "R10");
        exp_cmd(5, 4, 2, 8'h12, 2, 9, "R10");

        // channel mask: port 2 may not use channel 2
        do_reset(2);
        mask_r[2*NCH + 2] = 1'b0;
        miss_seq(2, 2, 8'h52, 1'b0, 2, "R9");
        miss_seq(2, 2, 8'h52, 1'b0, 2, "R9");
        miss_seq(1, 2, 8'h52, 1'b0, 2, "R9");
        miss_seq(2, 2, 8'h52, 1'b1, 2, "R9");
        raise(4'b0010);
        wait_idle();
        exp_cmd(0, 3, 2, 8'h52, 1, 0, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule